// File: doc/BRIEF.md
# AXI ID Masked Event Filter

This block sits beside an AXI slave port and watches the read-address and write-address handshakes. Each accepted address whose ID passes a programmable compare produces a single-cycle strobe. There is one strobe for qualified reads and one for qualified writes. A performance counter tallies these strobes as its filtered read event (code 0x41) and filtered write event (code 0x42). The read and write paths use the same filter setting, so both filtered events always look at the same ID and the same mask.

The setting is held in one 32-bit register. Bits 15:0 hold the target ID. Bits 31:16 hold the ID mask, stored bit-inverted. Software therefore writes its intended value XORed with 0xFFFF0000. When the enhanced variant is built (parameter `ENHANCED`), the block also keeps one byte total per direction. Each total adds the size of every qualified burst, so software can read bytes instead of burst counts. A burst's size is (len+1) shifted left by size, taken at the address handshake.

The block only observes the address channels. It never drives ready and applies no back-pressure. A beat counts only in a cycle where valid and ready are both high, however long valid was held before. The strobes, totals and register readback are plain control outputs and have no handshake.

Top module: `axid_evt_filter`

## Requirements
- R1: After reset, `cfg_rdata` reads 0, both strobes are low and both byte totals are 0. A register value of 0 compares every ID bit against target 0, so only ID 0 qualifies.
- R2: A register write at a clock edge with `cfg_we` high makes `cfg_rdata` equal `cfg_wdata` from the next cycle on. Bits 15:0 are the target and bits 31:16 are the inverted mask. Without a write, the register holds its value.
- R3: A strobe is high for exactly the one cycle after each edge where its channel's valid and ready are both high and the ID qualifies. Valid without ready, or ready without valid, gives no strobe. Back-to-back handshakes give back-to-back strobes.
- R4: An ID qualifies when ((id XOR reg[15:0]) AND NOT reg[31:16]) is 0, with the ID zero-extended to 16 bits. A mask field of 0x0000 requires an exact match. A mask field of 0xFFFF accepts any ID. Target bits above the ID width that are compared can never match.
- R5: The read and write channels are judged independently against the same setting, and they may both strobe in the same cycle.
- R6: A handshake at the same edge as a register write is judged with the previous setting. The new setting applies from the following edge.
- R7: With `ENHANCED=1`, each qualified handshake adds (len+1)·2^size to its direction's byte total. The total updates at the same edge that raises the strobe.
- R8: A register write resets both byte totals to 0. This clear takes priority over a qualified handshake at the same edge.
- R9: A byte total saturates at all ones and never wraps.
- R10: With `ENHANCED=0`, the byte outputs stay 0 and the strobes behave as in the enhanced build.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Filter register write strobe |
| cfg_wdata | input | 32 | Filter register write value (mask half already inverted) |
| cfg_rdata | output | 32 | Filter register contents |
| ar_valid | input | 1 | Read address valid (observed) |
| ar_ready | input | 1 | Read address ready (observed) |
| ar_id | input | ID_W | Read address ID |
| ar_len | input | LEN_W | Read burst length minus one |
| ar_size | input | SIZE_W | Read beat size, log2 bytes |
| aw_valid | input | 1 | Write address valid (observed) |
| aw_ready | input | 1 | Write address ready (observed) |
| aw_id | input | ID_W | Write address ID |
| aw_len | input | LEN_W | Write burst length minus one |
| aw_size | input | SIZE_W | Write beat size, log2 bytes |
| rd_hit | output | 1 | Qualified read strobe |
| wr_hit | output | 1 | Qualified write strobe |
| rd_bytes | output | ACC_W | Byte total of qualified reads |
| wr_bytes | output | ACC_W | Byte total of qualified writes |

## Verification
On every cycle, the checker ties each strobe to the previous cycle's handshake and ID compare, using the register as seen at the ports. It also checks that the register changes only on a write and that a write clears both totals. It checks that a total moves only with its strobe and never goes down between clears. The exact byte sums, the saturation value, the effect of a write that lands on the same edge as a handshake, and the plain build's zero totals all depend on the burst arithmetic. Only the bench's sweeps can show these. Those sweeps run every ID against every target under several masks, while varying the lengths and sizes.

// File: rtl/axid_filt_pkg.sv
package axid_filt_pkg;
  localparam int FID_W = 16;

  typedef struct packed {
    logic [FID_W-1:0] inv_mask;
    logic [FID_W-1:0] target;
  } filt_cfg_t;

  // Qualification rule: every bit cleared in the stored inverted mask is compared.
  function automatic logic id_qualifies(filt_cfg_t c, logic [FID_W-1:0] id);
    return ((id ^ c.target) & ~c.inv_mask) == '0;
  endfunction
endpackage

// File: rtl/axid_filt_reg.sv
module axid_filt_reg
  import axid_filt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output filt_cfg_t   cfg
);
  always_ff @(posedge clk) begin
    if (!rst_n)     cfg <= '0;
    else if (wr_en) cfg <= filt_cfg_t'(wr_data);
  end
endmodule

// File: rtl/axid_chan_match.sv
module axid_chan_match
  import axid_filt_pkg::*;
#(
  parameter int ID_W    = 16,
  parameter int LEN_W   = 8,
  parameter int SIZE_W  = 3,
  parameter int BURST_W = LEN_W + (1 << SIZE_W)
)(
  input  logic               clk,
  input  logic               rst_n,
  input  filt_cfg_t          cfg,
  input  logic               valid,
  input  logic               ready,
  input  logic [ID_W-1:0]    id,
  input  logic [LEN_W-1:0]   len,
  input  logic [SIZE_W-1:0]  size,
  output logic               hit_now,
  output logic               hit_q,
  output logic [BURST_W-1:0] burst_bytes
);
  logic [FID_W-1:0]   id_ext;
  logic [BURST_W-1:0] beats;

  assign id_ext      = FID_W'(id);
  assign hit_now     = valid && ready && id_qualifies(cfg, id_ext);
  assign beats       = BURST_W'(len) + BURST_W'(1);
  assign burst_bytes = beats << size;

  always_ff @(posedge clk) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= hit_now;
  end
endmodule

// File: rtl/axid_byte_acc.sv
module axid_byte_acc #(
  parameter int IN_W  = 16,
  parameter int ACC_W = 32
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             add_en,
  input  logic [IN_W-1:0]  add_val,
  output logic [ACC_W-1:0] acc_q
);
  localparam int SUM_W = ((ACC_W > IN_W) ? ACC_W : IN_W) + 1;

  logic [SUM_W-1:0] sum;
  logic             sat;

  assign sum = SUM_W'(acc_q) + SUM_W'(add_val);
  assign sat = |sum[SUM_W-1:ACC_W];

  always_ff @(posedge clk) begin
    if (!rst_n)      acc_q <= '0;
    else if (clr)    acc_q <= '0;
    else if (add_en) acc_q <= sat ? '1 : sum[ACC_W-1:0];
  end
endmodule

// File: rtl/axid_evt_filter.sv
module axid_evt_filter
  import axid_filt_pkg::*;
#(
  parameter int ID_W     = 16,
  parameter int LEN_W    = 8,
  parameter int SIZE_W   = 3,
  parameter int ACC_W    = 32,
  parameter bit ENHANCED = 1'b1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              ar_valid,
  input  logic              ar_ready,
  input  logic [ID_W-1:0]   ar_id,
  input  logic [LEN_W-1:0]  ar_len,
  input  logic [SIZE_W-1:0] ar_size,
  input  logic              aw_valid,
  input  logic              aw_ready,
  input  logic [ID_W-1:0]   aw_id,
  input  logic [LEN_W-1:0]  aw_len,
  input  logic [SIZE_W-1:0] aw_size,
  output logic              rd_hit,
  output logic              wr_hit,
  output logic [ACC_W-1:0]  rd_bytes,
  output logic [ACC_W-1:0]  wr_bytes
);
  localparam int BURST_W = LEN_W + (1 << SIZE_W);
  localparam int NCH     = 2;

  filt_cfg_t          cfg_q;
  logic [NCH-1:0]     ch_valid, ch_ready, ch_hit_now, ch_hit_q;
  logic [ID_W-1:0]    ch_id   [NCH];
  logic [LEN_W-1:0]   ch_len  [NCH];
  logic [SIZE_W-1:0]  ch_size [NCH];
  logic [BURST_W-1:0] ch_burst[NCH];
  logic [ACC_W-1:0]   ch_acc  [NCH];

  axid_filt_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_data (cfg_wdata),
    .cfg     (cfg_q)
  );
  assign cfg_rdata = cfg_q;

  // Channel 0 is the read address channel, channel 1 the write address channel.
  assign ch_valid   = {aw_valid, ar_valid};
  assign ch_ready   = {aw_ready, ar_ready};
  assign ch_id[0]   = ar_id;
  assign ch_id[1]   = aw_id;
  assign ch_len[0]  = ar_len;
  assign ch_len[1]  = aw_len;
  assign ch_size[0] = ar_size;
  assign ch_size[1] = aw_size;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    axid_chan_match #(
      .ID_W    (ID_W),
      .LEN_W   (LEN_W),
      .SIZE_W  (SIZE_W),
      .BURST_W (BURST_W)
    ) u_match (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg         (cfg_q),
      .valid       (ch_valid[ch]),
      .ready       (ch_ready[ch]),
      .id          (ch_id[ch]),
      .len         (ch_len[ch]),
      .size        (ch_size[ch]),
      .hit_now     (ch_hit_now[ch]),
      .hit_q       (ch_hit_q[ch]),
      .burst_bytes (ch_burst[ch])
    );

    if (ENHANCED) begin : g_acc
      axid_byte_acc #(
        .IN_W  (BURST_W),
        .ACC_W (ACC_W)
      ) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cfg_we),
        .add_en  (ch_hit_now[ch]),
        .add_val (ch_burst[ch]),
        .acc_q   (ch_acc[ch])
      );
    end else begin : g_noacc
      assign ch_acc[ch] = '0;
    end
  end

  assign rd_hit   = ch_hit_q[0];
  assign wr_hit   = ch_hit_q[1];
  assign rd_bytes = ch_acc[0];
  assign wr_bytes = ch_acc[1];
endmodule

// File: rtl/axid_evt_filter_chk.sv
module axid_evt_filter_chk #(
  parameter int ID_W     = 16,
  parameter int ACC_W    = 32,
  parameter bit ENHANCED = 1'b1
)(
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [31:0]      cfg_wdata,
  input logic [31:0]      cfg_rdata,
  input logic             ar_valid,
  input logic             ar_ready,
  input logic [ID_W-1:0]  ar_id,
  input logic             aw_valid,
  input logic             aw_ready,
  input logic [ID_W-1:0]  aw_id,
  input logic             rd_hit,
  input logic             wr_hit,
  input logic [ACC_W-1:0] rd_bytes,
  input logic [ACC_W-1:0] wr_bytes
);
  logic [15:0] cmp_bits;
  logic        ar_ok, aw_ok;

  assign cmp_bits = ~cfg_rdata[31:16];
  assign ar_ok = ar_valid && ar_ready && (((16'(ar_id) ^ cfg_rdata[15:0]) & cmp_bits) == 16'h0);
  assign aw_ok = aw_valid && aw_ready && (((16'(aw_id) ^ cfg_rdata[15:0]) & cmp_bits) == 16'h0);

  // R2: the register loads on a write and holds otherwise
  a_r2_cfg_load: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_we) |-> cfg_rdata == $past(cfg_wdata));
  a_r2_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_we) |-> $stable(cfg_rdata));
  // R3: no strobe without an accepted handshake
  a_r3_rd_needs_hs: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |-> $past(ar_valid && ar_ready));
  a_r3_wr_needs_hs: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |-> $past(aw_valid && aw_ready));
  // R4 R6: strobe follows the compare against the register as it was at the handshake edge
  a_r4_rd_rule: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit == $past(ar_ok));
  a_r4_wr_rule: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit == $past(aw_ok));

  if (ENHANCED) begin : g_enh
    // R8: a register write empties both totals
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cfg_we) |-> (rd_bytes == '0) && (wr_bytes == '0));
    // R7: totals move only together with their strobe
    a_r7_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_hit && !$past(cfg_we)) |-> $stable(rd_bytes));
    a_r7_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_hit && !$past(cfg_we)) |-> $stable(wr_bytes));
    // R9: totals never wrap between clears
    a_r9_rd_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cfg_we) |-> rd_bytes >= $past(rd_bytes));
    a_r9_wr_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cfg_we) |-> wr_bytes >= $past(wr_bytes));
  end
endmodule

bind axid_evt_filter axid_evt_filter_chk #(
  .ID_W     (ID_W),
  .ACC_W    (ACC_W),
  .ENHANCED (ENHANCED)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_wdata (cfg_wdata),
  .cfg_rdata (cfg_rdata),
  .ar_valid  (ar_valid),
  .ar_ready  (ar_ready),
  .ar_id     (ar_id),
  .aw_valid  (aw_valid),
  .aw_ready  (aw_ready),
  .aw_id     (aw_id),
  .rd_hit    (rd_hit),
  .wr_hit    (wr_hit),
  .rd_bytes  (rd_bytes),
  .wr_bytes  (wr_bytes)
);

// File: tb/axid_evt_filter_tb_top.sv
module axid_evt_filter_tb_top;
  localparam int ID_W = 4;
  localparam int LEN_W = 8;
  localparam int SIZE_W = 3;
  localparam int ACC_W = 16;
  localparam int ACC_MAX = (1 << ACC_W) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_we;
  logic [31:0] cfg_wdata;
  logic ar_valid, ar_ready, aw_valid, aw_ready;
  logic [ID_W-1:0] ar_id, aw_id;
  logic [LEN_W-1:0] ar_len, aw_len;
  logic [SIZE_W-1:0] ar_size, aw_size;
  logic [31:0] cfg_rdata, p_cfg_rdata;
  logic rd_hit, wr_hit, p_rd_hit, p_wr_hit;
  logic [ACC_W-1:0] rd_bytes, wr_bytes, p_rd_bytes, p_wr_bytes;

  always #4 clk = ~clk;

  axid_evt_filter #(.ID_W(ID_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W), .ACC_W(ACC_W), .ENHANCED(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id), .ar_len(ar_len), .ar_size(ar_size),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id), .aw_len(aw_len), .aw_size(aw_size),
    .rd_hit(rd_hit), .wr_hit(wr_hit), .rd_bytes(rd_bytes), .wr_bytes(wr_bytes));

  axid_evt_filter #(.ID_W(ID_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W), .ACC_W(ACC_W), .ENHANCED(1'b0)) dut_plain_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(p_cfg_rdata),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id), .ar_len(ar_len), .ar_size(ar_size),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id), .aw_len(aw_len), .aw_size(aw_size),
    .rd_hit(p_rd_hit), .wr_hit(p_wr_hit), .rd_bytes(p_rd_bytes), .wr_bytes(p_wr_bytes));

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [15:0] m_tgt, m_cmp;
  int acc_r, acc_w;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_ok(input logic [ID_W-1:0] id);
    return ((16'(id) ^ m_tgt) & m_cmp) == 16'h0;
  endfunction

  function automatic int sat_add(input int a, input logic [LEN_W-1:0] l, input logic [SIZE_W-1:0] s);
    int t;
    t = a + ((int'(l) + 1) << s);
    return (t > ACC_MAX) ? ACC_MAX : t;
  endfunction

  task automatic idle_inputs();
    cfg_we = 1'b0; ar_valid = 1'b0; ar_ready = 1'b0; aw_valid = 1'b0; aw_ready = 1'b0;
  endtask

  // User value: target t, compare mask m (1 = compare). Register holds it with the mask half inverted.
  task automatic write_cfg(input logic [15:0] t, input logic [15:0] m);
    idle_inputs();
    cfg_we = 1'b1;
    cfg_wdata = {m, t} ^ 32'hFFFF_0000;
    @(negedge clk);
    cfg_we = 1'b0;
    m_tgt = t; m_cmp = m; acc_r = 0; acc_w = 0;
    chk("R2 cfg readback", cfg_rdata, {~m, t});
    chk("R8 rd_bytes cleared", rd_bytes, 0);
    chk("R8 wr_bytes cleared", wr_bytes, 0);
  endtask

  task automatic hs2(input bit arv, input bit arr, input logic [ID_W-1:0] arid,
                     input logic [LEN_W-1:0] arl, input logic [SIZE_W-1:0] ars,
                     input bit awv, input bit awr, input logic [ID_W-1:0] awid,
                     input logic [LEN_W-1:0] awl, input logic [SIZE_W-1:0] aws);
    bit er, ew;
    ar_valid = arv; ar_ready = arr; ar_id = arid; ar_len = arl; ar_size = ars;
    aw_valid = awv; aw_ready = awr; aw_id = awid; aw_len = awl; aw_size = aws;
    er = arv && arr && exp_ok(arid);
    ew = awv && awr && exp_ok(awid);
    if (er) acc_r = sat_add(acc_r, arl, ars);
    if (ew) acc_w = sat_add(acc_w, awl, aws);
    @(negedge clk);
    ar_valid = 1'b0; aw_valid = 1'b0;
    chk("R3 R4 rd_hit", rd_hit, er);
    chk("R5 wr_hit", wr_hit, ew);
    chk("R7 R9 rd_bytes", rd_bytes, acc_r);
    chk("R7 R9 wr_bytes", wr_bytes, acc_w);
    chk("R10 plain rd_hit", p_rd_hit, er);
    chk("R10 plain bytes", {p_rd_bytes, p_wr_bytes}, 0);
  endtask

  initial begin
    logic [15:0] masks [5];
    masks = '{16'hFFFF, 16'h0000, 16'h0005, 16'h000A, 16'h000C};
    rst_n = 1'b0;
    idle_inputs();
    cfg_wdata = '0;
    ar_id = '0; ar_len = '0; ar_size = '0; aw_id = '0; aw_len = '0; aw_size = '0;
    repeat (3) @(negedge clk);
    chk("R1 cfg_rdata in reset", cfg_rdata, 0);
    chk("R1 strobes in reset", {rd_hit, wr_hit}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cfg_rdata after reset", cfg_rdata, 0);
    chk("R1 bytes after reset", {rd_bytes, wr_bytes}, 0);
    // Reset register value: every bit compared against target 0
    m_tgt = 16'h0000; m_cmp = 16'hFFFF; acc_r = 0; acc_w = 0;
    hs2(1, 1, 4'd0, 8'd1, 3'd1, 1, 1, 4'd1, 8'd0, 3'd0);
    chk("R1 reset filter takes only ID 0", {rd_hit, wr_hit}, 2'b10);

    // R4 R5 R7: all targets against all IDs under several masks
    for (int mi = 0; mi < 5; mi++) begin
      for (int t = 0; t < 16; t++) begin
        write_cfg(16'(t), masks[mi]);
        for (int id = 0; id < 16; id++) begin
          hs2(1, 1, 4'(id), 8'(id * 7), 3'(id), 1, 1, 4'(15 - id), 8'(id), 3'(7 - id));
        end
      end
    end

    // R3: handshake qualification and back-to-back strobes
    write_cfg(16'h0000, 16'h0000);
    hs2(1, 0, 4'd3, 8'd2, 3'd2, 0, 1, 4'd3, 8'd2, 3'd2);
    chk("R3 no strobe without both valid and ready", {rd_hit, wr_hit}, 0);
    hs2(1, 0, 4'd3, 8'd2, 3'd2, 1, 0, 4'd3, 8'd2, 3'd2);
    hs2(1, 1, 4'd3, 8'd2, 3'd2, 1, 1, 4'd9, 8'd0, 3'd3);
    chk("R3 single strobe after stall", {rd_hit, wr_hit}, 2'b11);
    hs2(1, 1, 4'd4, 8'd0, 3'd0, 1, 1, 4'd4, 8'd0, 3'd0);
    chk("R3 back-to-back strobe", rd_hit, 1);

    // R6 R8: write coinciding with a handshake
    idle_inputs();
    cfg_we = 1'b1;
    cfg_wdata = {16'h000F, 16'h0005} ^ 32'hFFFF_0000;
    ar_valid = 1'b1; ar_ready = 1'b1; ar_id = 4'd3; ar_len = 8'd0; ar_size = 3'd0;
    @(negedge clk);
    idle_inputs();
    chk("R6 same-edge handshake uses old setting", rd_hit, 1);
    chk("R8 clear wins over same-edge handshake", rd_bytes, 0);
    m_tgt = 16'h0005; m_cmp = 16'h000F; acc_r = 0; acc_w = 0;
    hs2(1, 1, 4'd3, 8'd0, 3'd0, 0, 0, 4'd0, 8'd0, 3'd0);
    chk("R6 new setting rejects ID 3", rd_hit, 0);
    hs2(1, 1, 4'd5, 8'd3, 3'd1, 0, 0, 4'd0, 8'd0, 3'd0);
    chk("R6 new setting accepts ID 5", rd_bytes, 8);

    // R9: saturation
    write_cfg(16'h0000, 16'h0000);
    for (int k = 0; k < 3; k++) hs2(1, 1, 4'd1, 8'hFF, 3'd7, 1, 1, 4'd2, 8'd0, 3'd0);
    chk("R9 rd_bytes saturated", rd_bytes, 16'hFFFF);
    chk("R9 wr_bytes unaffected", wr_bytes, 3);

    // R4: compared target bits above the ID width never match
    write_cfg(16'h0010, 16'hFFFF);
    hs2(1, 1, 4'd0, 8'd0, 3'd0, 1, 1, 4'd15, 8'd0, 3'd0);
    chk("R4 high target bit blocks all IDs", {rd_hit, wr_hit}, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1-sequence hung actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule